// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A table of 2-bit saturating counters is indexed by a hash of the fetch address and a global record of recent branch outcomes. The low `IDX_W` bits of the word-aligned fetch address are XORed with the outcome history to form the index. In the same cycle the block returns the counter's taken/not-taken decision. It also returns the index it used and the current history value, so the pipeline can carry both to resolution.

When the branch resolves, the pipeline presents the carried index, the real outcome and a valid strobe. The addressed counter moves one step toward the outcome, and the outcome enters the history. After a misprediction the pipeline can reload the history from the snapshot it carried, which undoes the outcomes shifted in along the wrong path. The table has no tags, so branches whose hashed indexes collide share a counter. `HIST_W` must not exceed `IDX_W`.

Top module: `gshare_predictor`

## Requirements
- R1: `predIdx` equals `fetchPc[IDX_W+1:2]` XOR the history zero-extended to `IDX_W` bits. Address bits 1:0 and bits above `IDX_W+1` have no effect on the index.
- R2: Counter values 0/1/2/3 mean strongly not-taken, weakly not-taken, weakly taken and strongly taken. `predTaken` is bit 1 of the counter at `predIdx`.
- R3: After reset every counter holds 1, so every address predicts not-taken, and `predHist` is 0.
- R4: An update with `updTaken`=1 raises the counter at `updIdx` by one. A counter at 3 stays at 3.
- R5: An update with `updTaken`=0 lowers the counter at `updIdx` by one. A counter at 0 stays at 0.
- R6: An update without restore shifts `updTaken` into bit 0 of the history, with 1 meaning taken, and drops the oldest bit.
- R7: `restoreValid` loads `restoreHist` into the history and leaves every counter unchanged. When it coincides with an update, the loaded value wins over the shift, and the counter update is still applied.
- R8: In a cycle with neither update nor restore, the history does not change.
- R9: Updates take effect at the next clock edge. A prediction made in the update cycle still sees the old counter value.
- R10: A counter at strongly taken needs two not-taken updates before its prediction turns to not-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fetchPc | input | PC_W | Fetch address of the branch being predicted |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predIdx | output | IDX_W | Table index used for this prediction |
| predHist | output | HIST_W | Current global history, to be kept as a restore snapshot |
| updValid | input | 1 | Resolution strobe |
| updIdx | input | IDX_W | Index carried from the prediction of the resolving branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |
| restoreValid | input | 1 | History reload strobe |
| restoreHist | input | HIST_W | History snapshot to reload |

## Verification
The bench uses the default build: a 32-bit address, an 8-bit index giving 256 counters, and 8 history bits. Because the history is as wide as the index, every index bit is flipped by the history, and the XOR check covers the full width. Pairing each update with a restore to zero holds the history still. This lets the bench walk a single counter through both saturation points and the hysteresis sequence at a known address. Separate runs then check the history shift, its overflow, and the priority of the reload.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntWrite;   // write the addressed counter
    logic cntUp;      // direction of the counter step
    logic histShift;  // shift outcome into history
    logic histLoad;   // reload history from snapshot
  } gshareStrobes_t;

  localparam logic [1:0] CNT_MIN     = 2'd0;
  localparam logic [1:0] CNT_WEAK_NT = 2'd1;
  localparam logic [1:0] CNT_MAX     = 2'd3;

endpackage

// File: rtl/gshare_ctrl.sv
module gshare_ctrl
  import gshare_pkg::*;
(
  input  logic           updValid,
  input  logic           updTaken,
  input  logic           restoreValid,
  output gshareStrobes_t strobes
);

  always_comb begin
    strobes.cntWrite  = updValid;
    strobes.cntUp     = updTaken;
    // a reload overrides the shift of the same cycle
    strobes.histLoad  = restoreValid;
    strobes.histShift = updValid & ~restoreValid;
  end

endmodule

// File: rtl/gshare_datapath.sv
module gshare_datapath
  import gshare_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  gshareStrobes_t    strobes,
  input  logic [IDX_W-1:0]  pcBits,
  input  logic [IDX_W-1:0]  updIdx,
  input  logic              updTaken,
  input  logic [HIST_W-1:0] restoreHist,
  output logic              predTaken,
  output logic [IDX_W-1:0]  predIdx,
  output logic [HIST_W-1:0] histQ
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int PAD_W   = IDX_W - HIST_W;

  logic [1:0]        cntTable [ENTRIES];
  logic [IDX_W-1:0]  histExt;
  logic [HIST_W-1:0] histShifted;
  logic [1:0]        curCnt;
  logic [1:0]        nextCnt;

  generate
    if (PAD_W > 0) begin : gPad
      assign histExt = {{PAD_W{1'b0}}, histQ};
    end else begin : gNoPad
      assign histExt = histQ;
    end
    if (HIST_W > 1) begin : gShiftWide
      assign histShifted = {histQ[HIST_W-2:0], updTaken};
    end else begin : gShiftOne
      assign histShifted = updTaken;
    end
  endgenerate

  // lookup
  assign predIdx   = pcBits ^ histExt;
  assign predTaken = cntTable[predIdx][1];

  // saturating step
  always_comb begin
    curCnt  = cntTable[updIdx];
    nextCnt = curCnt;
    if (strobes.cntUp) begin
      if (curCnt != CNT_MAX) nextCnt = curCnt + 2'd1;
    end else begin
      if (curCnt != CNT_MIN) nextCnt = curCnt - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) cntTable[i] <= CNT_WEAK_NT;
    end else if (strobes.cntWrite) begin
      cntTable[updIdx] <= nextCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  histQ <= '0;
    else if (strobes.histLoad)  histQ <= restoreHist;
    else if (strobes.histShift) histQ <= histShifted;
  end

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 8,
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   fetchPc,
  output logic              predTaken,
  output logic [IDX_W-1:0]  predIdx,
  output logic [HIST_W-1:0] predHist,
  input  logic              updValid,
  input  logic [IDX_W-1:0]  updIdx,
  input  logic              updTaken,
  input  logic              restoreValid,
  input  logic [HIST_W-1:0] restoreHist
);

  gshareStrobes_t strobes;
  logic unusedPcBits;

  assign unusedPcBits = ^{fetchPc[PC_W-1:IDX_W+2], fetchPc[1:0]};

  gshare_ctrl uCtrl (
    .updValid     (updValid),
    .updTaken     (updTaken),
    .restoreValid (restoreValid),
    .strobes      (strobes)
  );

  gshare_datapath #(.IDX_W(IDX_W), .HIST_W(HIST_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .pcBits      (fetchPc[IDX_W+1:2]),
    .updIdx      (updIdx),
    .updTaken    (updTaken),
    .restoreHist (restoreHist),
    .predTaken   (predTaken),
    .predIdx     (predIdx),
    .histQ       (predHist)
  );

endmodule

// File: rtl/gshare_checker.sv
module gshare_checker #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 8,
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [PC_W-1:0]   fetchPc,
  input logic [IDX_W-1:0]  predIdx,
  input logic [HIST_W-1:0] predHist,
  input logic              updValid,
  input logic              updTaken,
  input logic              restoreValid,
  input logic [HIST_W-1:0] restoreHist
);

  a_r1_index_hash: assert property (@(posedge clk) disable iff (!rstN)
    predIdx == (fetchPc[IDX_W+1:2] ^ IDX_W'(predHist)));

  a_r6_hist_shift: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !restoreValid) |=>
      predHist == HIST_W'({$past(predHist), $past(updTaken)}));

  a_r7_hist_restore: assert property (@(posedge clk) disable iff (!rstN)
    restoreValid |=> predHist == $past(restoreHist));

  a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!updValid && !restoreValid) |=> $stable(predHist));

endmodule

bind gshare_predictor gshare_checker #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .fetchPc      (fetchPc),
  .predIdx      (predIdx),
  .predHist     (predHist),
  .updValid     (updValid),
  .updTaken     (updTaken),
  .restoreValid (restoreValid),
  .restoreHist  (restoreHist)
);

// File: tb/gshare_predictor_test.sv
module gshare_predictor_test;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32, IDX_W = 8, HIST_W = 8;

  // {index[7:0], taken, expected prediction after}; history held at 0
  localparam logic [9:0] VEC [11] = '{
    {8'd5,   1'b1, 1'b1},  // R4 1->2
    {8'd5,   1'b1, 1'b1},  // R4 2->3
    {8'd5,   1'b1, 1'b1},  // R4 saturate at 3
    {8'd5,   1'b0, 1'b1},  // R10 3->2 still taken
    {8'd5,   1'b0, 1'b0},  // R10 2->1 flips
    {8'd5,   1'b0, 1'b0},  // R5 1->0
    {8'd5,   1'b0, 1'b0},  // R5 saturate at 0
    {8'd5,   1'b1, 1'b0},  // R4 0->1
    {8'd5,   1'b1, 1'b1},  // R2 1->2 taken
    {8'd200, 1'b1, 1'b1},  // R2 other entry
    {8'd6,   1'b0, 1'b0}   // R5 1->0
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [PC_W-1:0]   fetchPc = '0;
  logic              predTaken;
  logic [IDX_W-1:0]  predIdx;
  logic [HIST_W-1:0] predHist;
  logic              updValid = 1'b0;
  logic [IDX_W-1:0]  updIdx = '0;
  logic              updTaken = 1'b0;
  logic              restoreValid = 1'b0;
  logic [HIST_W-1:0] restoreHist = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gshare_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) uut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predTaken(predTaken),
    .predIdx(predIdx), .predHist(predHist), .updValid(updValid),
    .updIdx(updIdx), .updTaken(updTaken), .restoreValid(restoreValid),
    .restoreHist(restoreHist)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one update cycle; inputs set at negedge, released at next negedge
  task automatic step(input logic upd, input logic [7:0] idx, input logic tk,
                      input logic rst, input logic [7:0] rh);
    @(negedge clk);
    updValid = upd; updIdx = idx; updTaken = tk;
    restoreValid = rst; restoreHist = rh;
    @(negedge clk);
    updValid = 1'b0; restoreValid = 1'b0;
  endtask

  function automatic logic [31:0] pcFor(input logic [7:0] idx);
    return {22'h0, idx, 2'b00};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R3 reset state
    check("R3 hist", predHist, 0);
    fetchPc = pcFor(8'd0);   #1 check("R3 pred idx0", predTaken, 0);
    fetchPc = pcFor(8'd255); #1 check("R3 pred idx255", predTaken, 0);

    // vector walk, history held at 0 by restore (R7 priority)
    foreach (VEC[i]) begin
      step(1'b1, VEC[i][9:2], VEC[i][1], 1'b1, 8'h00);
      fetchPc = pcFor(VEC[i][9:2]);
      #1 check("R2/R4/R5/R10 vector", predTaken, VEC[i][0]);
    end
    check("R7 restore beats shift", predHist, 0);

    // R9: same-cycle read sees old value (idx 9 at 1)
    @(negedge clk);
    fetchPc = pcFor(8'd9);
    updValid = 1'b1; updIdx = 8'd9; updTaken = 1'b1;
    restoreValid = 1'b1; restoreHist = 8'h00;
    #1 check("R9 before edge", predTaken, 0);
    @(negedge clk);
    updValid = 1'b0; restoreValid = 1'b0;
    #1 check("R9 after edge", predTaken, 1);

    // R1 index hash, with restore to a known history
    step(1'b0, 8'd0, 1'b0, 1'b1, 8'hA5);
    fetchPc = 32'h0000_03FF; #1 check("R1 idx", predIdx, 8'h5A);
    fetchPc = 32'hFFFF_FFFC; #1 check("R1 idx high bits ignored", predIdx, 8'h5A);
    // R7 table unchanged by restore: idx5 at 2 -> pc bits 5^A5
    fetchPc = pcFor(8'h05 ^ 8'hA5); #1 check("R7 table kept", predTaken, 1);

    // R6 shifting
    step(1'b0, 8'd0, 1'b0, 1'b1, 8'h00);
    step(1'b1, 8'd50, 1'b1, 1'b0, 8'h00);
    step(1'b1, 8'd50, 1'b0, 1'b0, 8'h00);
    step(1'b1, 8'd50, 1'b1, 1'b0, 8'h00);
    step(1'b1, 8'd50, 1'b1, 1'b0, 8'h00);
    check("R6 hist pattern", predHist, 8'h0B);
    for (int k = 0; k < 6; k++) step(1'b1, 8'd51, 1'b0, 1'b0, 8'h00);
    check("R6 oldest dropped", predHist, 8'hC0);

    // R8 idle
    repeat (4) @(negedge clk);
    check("R8 hist stable", predHist, 8'hC0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule